// File: doc/BRIEF.md
# Display Data Fetcher with Tone Synthesis

This block is a memory-mapped coprocessor. It sits behind a 128-byte register window and holds eight graphics fetchers. Each fetcher owns a 12-bit pointer into an internal 2 KiB graphics ROM. A read through a fetcher's view returns the ROM byte at its pointer and then moves the pointer down by one. Six views exist. They differ in the bit arrangement applied to the byte and in whether the fetcher's window flag gates it. Each fetcher compares the low byte of its pointer against a start count and an end count. The result is a flag that opens and closes a window of scanlines in which graphics appear.

The three highest-numbered fetchers can each be turned into a square-wave tone generator. In that mode the low pointer byte becomes a reloading down-counter. The counter is clocked either by bus reads or by an external oscillator tick. The start and end comparators then act as duty-cycle thresholds. The three tone flags pass through a fixed nonlinear table that produces a 4-bit audio level, which the host reads back. An 8-bit pseudo-random register steps on each of its reads.

The bus interface is a plain strobe interface. A read or write strobe is accepted in the cycle it is high, one access per cycle, with no back-pressure. Read data is a combinational function of the address and the present state, and must be taken in the strobe cycle. Side effects of a read, such as pointer moves and random-register steps, land at the clock edge that ends that cycle. Only one of the two strobes is high in any cycle.

Top module: `gfx_fetch_synth`

## Requirements
- R1: After reset, every pointer, start count, end count, flag, tone bit, clock-select bit and the random register is zero. Reads at 0x38-0x3F and at 0x00-0x07 then return 0x00.
- R2: A read at 0x08-0x37 uses the fetcher numbered by address bits 2:0. It returns the ROM byte at pointer bits 10:0, where the ROM byte at address a is a[7:0] XOR {a[10:8], 5'b0}. When that fetcher is read-clocked and not in tone mode, the full 12-bit pointer then drops by one, borrowing across the low byte. Reads at 0x38-0x3F never move a pointer.
- R3: The views apply these arrangements to ROM byte b. 0x08-0x0F returns b unchanged. 0x10-0x17 returns b. 0x18-0x1F returns b with its nibbles exchanged. 0x20-0x27 returns b with bit k moved to bit 7-k. 0x28-0x2F returns b shifted toward bit 0 with 0 entering bit 7. 0x30-0x37 returns b shifted toward bit 7 with 0 entering bit 0.
- R4: Every view from 0x10 to 0x37 returns 0x00 while the fetcher's flag is clear. Reads at 0x38-0x3F return 0xFF when the flag is set and 0x00 when it is clear.
- R5: Writing the start count (0x40-0x47) sets the flag. Whenever the low pointer byte changes, through a write, a decrement or a reload, the new value is compared with the counts. Equal to the end count (0x48-0x4F) clears the flag; this takes precedence over the start count. Otherwise, equal to the start count sets the flag. Writes of the end count or of the upper pointer bits leave the flag alone.
- R6: A write at 0x50-0x57 loads the low pointer byte. A write at 0x58-0x5F loads pointer bits 11:8 from data bits 3:0. Only at 0x5D-0x5F does the same write also store data bit 5 as the clock select and data bit 4 as the tone enable. Data bits 7:4 at 0x58-0x5C, including bit 4 at 0x5C, have no effect.
- R7: In tone mode each clock event moves the low pointer byte down by one. When the decremented value would be 0xFF, the start count is loaded instead. Pointer bits 11:8 are held.
- R8: With clock select 1, the counter advances once per rising edge of the oscillator tick (a tick held high counts once), and reads through the views return data without moving the pointer. Without tone mode a tick-clocked pointer drops by one over its full 12 bits. With clock select 0 the read strobe clocks it.
- R9: The flags of fetchers 5, 6 and 7 form a 3-bit index, with fetcher 5 as bit 2. Index 0..7 maps to level 0x0, 0x4, 0x5, 0x9, 0x6, 0xA, 0xB, 0xF. Reads at 0x04-0x07 return {4'b0000, level}.
- R10: A read at 0x00-0x03 returns the random register and then shifts it left, filling bit 0 with the inverse of the XOR of bits 7, 5, 4 and 3. Starting from zero the value never becomes 0xFF and repeats after 255 reads.
- R11: Any read or write at 0x70-0x77 clears the random register to 0x00.
- R12: Writes at 0x00-0x3F, 0x60-0x6F and 0x78-0x7F change no state. Reads at 0x40-0x7F return 0x00. Apart from the clear of R11, such reads change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 7 | Register window offset |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wr | input | 1 | Write strobe, one access per cycle high |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address and state |
| osc_tick | input | 1 | Oscillator tick; its rising edges clock tick-selected counters |

## Verification
The bound checker watches a set of rules on every cycle:
- a read of fetcher 0's raw view decrements its pointer;
- masked views return zero while the flag is clear;
- the flag readback matches the flag;
- a start-count write leaves the flag set;
- the audio byte keeps its upper nibble zero;
- the random register never reaches 0xFF;
- an access to the clear range zeroes it.

The arrangement of each view, borrow across the pointer's low byte, end-over-start precedence, tone reload to the start count with held upper bits, single counting of a held tick, the mixing table and the 255-read period show only in the bench's scenarios.

// File: rtl/gfs_pkg.sv
package gfs_pkg;

  localparam int WIN_AW = 7;
  localparam int DW     = 8;
  localparam int MIX_W  = 3;

  // Window decode by address bits 6:3
  typedef enum logic [3:0] {
    RG_MISC  = 4'h0,  // random (bit2=0) / audio (bit2=1)
    RG_RAW   = 4'h1,
    RG_PLAIN = 4'h2,
    RG_SWAP  = 4'h3,
    RG_REV   = 4'h4,
    RG_SHR   = 4'h5,
    RG_SHL   = 4'h6,
    RG_FLAG  = 4'h7,
    RG_START = 4'h8,
    RG_END   = 4'h9,
    RG_PLO   = 4'hA,
    RG_PHI   = 4'hB,
    RG_MOV0  = 4'hC,
    RG_MOV1  = 4'hD,
    RG_RCLR  = 4'hE,
    RG_SPARE = 4'hF
  } region_e;

  function automatic logic is_fetch_view(input region_e r);
    return (r >= RG_RAW) && (r <= RG_SHL);
  endfunction

  function automatic logic [DW-1:0] shape_view(input region_e r,
                                               input logic [DW-1:0] b,
                                               input logic f);
    logic [DW-1:0] v;
    v = b;
    case (r)
      RG_SWAP: v = {b[3:0], b[7:4]};
      RG_REV:  for (int k = 0; k < DW; k++) v[k] = b[DW-1-k];
      RG_SHR:  v = {1'b0, b[7:1]};
      RG_SHL:  v = {b[6:0], 1'b0};
      default: v = b;
    endcase
    if (r == RG_RAW) return b;
    return f ? v : '0;
  endfunction

endpackage

// File: rtl/graphics_rom.sv
module graphics_rom #(
  parameter int AW = 11
) (
  input  logic [AW-1:0] addr,
  output logic [7:0]    data
);
  localparam int HI_W = AW - 8;

  // Computed image: low address byte folded with the bank bits
  logic [HI_W-1:0] bank;
  assign bank = addr[AW-1:8];
  assign data = addr[7:0] ^ 8'({bank, 5'b00000});
endmodule

// File: rtl/fetch_lane.sv
module fetch_lane #(
  parameter int PTR_W   = 12,
  parameter bit TONE_OK = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_start,
  input  logic             wr_end,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             rd_pulse,
  input  logic             tick_rise,
  output logic [PTR_W-1:0] ptr,
  output logic             flag
);
  localparam int HI_W = PTR_W - 8;

  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic [7:0]       start_q, end_q, lo_dec;
  logic             flag_q, flag_n;
  logic             tone_q, sel_q;
  logic             step, lo_moved;

  assign step   = sel_q ? tick_rise : rd_pulse;
  assign lo_dec = ptr_q[7:0] - 8'd1;

  always_comb begin
    ptr_n    = ptr_q;
    lo_moved = 1'b0;
    if (wr_lo) begin
      ptr_n[7:0] = wdata;
      lo_moved   = 1'b1;
    end else if (wr_hi) begin
      ptr_n[PTR_W-1:8] = wdata[HI_W-1:0];
    end else if (step) begin
      lo_moved = 1'b1;
      if (tone_q) ptr_n[7:0] = (lo_dec == 8'hFF) ? start_q : lo_dec;
      else        ptr_n      = ptr_q - PTR_W'(1);
    end
  end

  always_comb begin
    flag_n = flag_q;
    if (wr_start)                        flag_n = 1'b1;
    else if (lo_moved) begin
      if (ptr_n[7:0] == end_q)           flag_n = 1'b0;
      else if (ptr_n[7:0] == start_q)    flag_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q   <= '0;
      start_q <= '0;
      end_q   <= '0;
      flag_q  <= 1'b0;
      tone_q  <= 1'b0;
      sel_q   <= 1'b0;
    end else begin
      ptr_q  <= ptr_n;
      flag_q <= flag_n;
      if (wr_start) start_q <= wdata;
      if (wr_end)   end_q   <= wdata;
      if (TONE_OK && wr_hi) begin
        tone_q <= wdata[4];
        sel_q  <= wdata[5];
      end
    end
  end

  assign ptr  = ptr_q;
  assign flag = flag_q;
endmodule

// File: rtl/tone_mix.sv
module tone_mix (
  input  logic [2:0] sel,
  output logic [3:0] level
);
  always_comb begin
    unique case (sel)
      3'd0: level = 4'h0;
      3'd1: level = 4'h4;
      3'd2: level = 4'h5;
      3'd3: level = 4'h9;
      3'd4: level = 4'h6;
      3'd5: level = 4'hA;
      3'd6: level = 4'hB;
      default: level = 4'hF;
    endcase
  end
endmodule

// File: rtl/noise_reg.sv
module noise_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       clear,
  output logic [7:0] value
);
  logic [7:0] q;
  logic       fb;

  assign fb = ~(q[7] ^ q[5] ^ q[4] ^ q[3]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (clear) q <= '0;
    else if (step)  q <= {q[6:0], fb};
  end

  assign value = q;
endmodule

// File: rtl/gfx_fetch_synth.sv
module gfx_fetch_synth
  import gfs_pkg::*;
#(
  parameter int NUM_FETCH = 8,
  parameter int PTR_W     = 12,
  parameter int ROM_AW    = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [6:0]    bus_addr,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          osc_tick
);
  localparam int IDX_W      = $clog2(NUM_FETCH);
  localparam int TONE_LANES = MIX_W;

  region_e                      region;
  logic [IDX_W-1:0]             idx;
  logic [NUM_FETCH*PTR_W-1:0]   ptr_flat;
  logic [NUM_FETCH-1:0]         lane_flag;
  logic [ROM_AW-1:0]            rom_addr;
  logic [7:0]                   rom_byte;
  logic                         cur_flag;
  logic                         tick_q, tick_rise;
  logic [MIX_W-1:0]             mix_sel;
  logic [3:0]                   audio_lvl;
  logic [7:0]                   rng_val;

  assign region = region_e'(bus_addr[6:3]);
  assign idx    = bus_addr[IDX_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= osc_tick;
  end
  assign tick_rise = osc_tick & ~tick_q;

  for (genvar g = 0; g < NUM_FETCH; g++) begin : g_lane
    logic hit;
    assign hit = (idx == IDX_W'(g));
    fetch_lane #(
      .PTR_W  (PTR_W),
      .TONE_OK(g >= NUM_FETCH - TONE_LANES)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_start (bus_wr && hit && region == RG_START),
      .wr_end   (bus_wr && hit && region == RG_END),
      .wr_lo    (bus_wr && hit && region == RG_PLO),
      .wr_hi    (bus_wr && hit && region == RG_PHI),
      .wdata    (bus_wdata),
      .rd_pulse (bus_rd && hit && is_fetch_view(region)),
      .tick_rise(tick_rise),
      .ptr      (ptr_flat[g*PTR_W +: PTR_W]),
      .flag     (lane_flag[g])
    );
  end

  // Lowest-numbered tone lane drives the index MSB
  for (genvar k = 0; k < TONE_LANES; k++) begin : g_mix
    assign mix_sel[TONE_LANES-1-k] = lane_flag[NUM_FETCH-TONE_LANES+k];
  end

  tone_mix u_mix (.sel(mix_sel), .level(audio_lvl));

  noise_reg u_noise (
    .clk  (clk),
    .rst_n(rst_n),
    .step (bus_rd && region == RG_MISC && !bus_addr[2]),
    .clear((bus_rd || bus_wr) && region == RG_RCLR),
    .value(rng_val)
  );

  assign rom_addr = ptr_flat[idx*PTR_W +: ROM_AW];
  assign cur_flag = lane_flag[idx];

  graphics_rom #(.AW(ROM_AW)) u_rom (.addr(rom_addr), .data(rom_byte));

  always_comb begin
    bus_rdata = '0;
    unique case (region)
      RG_MISC:  bus_rdata = bus_addr[2] ? {4'b0000, audio_lvl} : rng_val;
      RG_RAW, RG_PLAIN, RG_SWAP, RG_REV, RG_SHR, RG_SHL:
                bus_rdata = shape_view(region, rom_byte, cur_flag);
      RG_FLAG:  bus_rdata = {8{cur_flag}};
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gfx_fetch_synth_chk.sv
module gfx_fetch_synth_chk #(
  parameter int NUM_FETCH = 8,
  parameter int PTR_W     = 12
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [6:0]                 bus_addr,
  input logic                       bus_rd,
  input logic                       bus_wr,
  input logic [7:0]                 bus_rdata,
  input logic [7:0]                 rng_val,
  input logic [NUM_FETCH*PTR_W-1:0] ptr_flat,
  input logic [NUM_FETCH-1:0]       lane_flag
);
  // R2
  raw_read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 7'h08)
    |=> ptr_flat[PTR_W-1:0] == $past(ptr_flat[PTR_W-1:0]) - PTR_W'(1));

  // R4
  masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 7'h10 && bus_addr <= 7'h37 && !lane_flag[bus_addr[2:0]])
    |-> bus_rdata == 8'h00);

  // R4
  flag_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[6:3] == 4'h7)
    |-> bus_rdata == {8{lane_flag[bus_addr[2:0]]}});

  // R5
  start_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_rd && bus_addr[6:3] == 4'h8)
    |=> lane_flag[$past(bus_addr[2:0])]);

  // R9
  audio_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr[6:2] == 5'b00001) |-> bus_rdata[7:4] == 4'h0);

  // R10
  rng_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rng_val != 8'hFF);

  // R11
  rng_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && bus_addr[6:3] == 4'hE) |=> rng_val == 8'h00);
endmodule

bind gfx_fetch_synth gfx_fetch_synth_chk #(
  .NUM_FETCH(NUM_FETCH),
  .PTR_W    (PTR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_rd   (bus_rd),
  .bus_wr   (bus_wr),
  .bus_rdata(bus_rdata),
  .rng_val  (rng_val),
  .ptr_flat (ptr_flat),
  .lane_flag(lane_flag)
);

// File: tb/test_gfx_fetch_synth.sv
module test_gfx_fetch_synth;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] bus_addr = '0;
  logic       bus_rd = 1'b0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       osc_tick = 1'b0;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;  // 125 MHz

  gfx_fetch_synth i_gfx_fetch_synth (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .osc_tick(osc_tick)
  );

  // {read?, requirement, offset, write data or expected read data}
  localparam int NV = 42;
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 4'd6,  7'h51, 8'h05},  // R6 low pointer fetcher 1
    {1'b0, 4'd6,  7'h59, 8'h02},  // R6 upper bits -> 0x205
    {1'b1, 4'd2,  7'h09, 8'h45},  // R2 raw ROM byte
    {1'b1, 4'd4,  7'h11, 8'h00},  // R4 masked while flag clear
    {1'b0, 4'd5,  7'h41, 8'h02},  // R5 start write sets flag
    {1'b1, 4'd4,  7'h39, 8'hFF},  // R4 readback set
    {1'b1, 4'd3,  7'h19, 8'h34},  // R3 nibble swap of 0x43
    {1'b0, 4'd5,  7'h49, 8'h00},  // R5 end count 0
    {1'b1, 4'd3,  7'h29, 8'h21},  // R3 shift right of 0x42
    {1'b1, 4'd3,  7'h21, 8'h82},  // R3 reversed 0x41
    {1'b1, 4'd5,  7'h39, 8'h00},  // R5 low byte hit end
    {1'b1, 4'd4,  7'h31, 8'h00},  // R4 masked, borrow follows
    {1'b1, 4'd2,  7'h09, 8'hDF},  // R2 pointer 0x1FF after borrow
    {1'b0, 4'd5,  7'h42, 8'h10},  // R5 fetcher 2 start
    {1'b0, 4'd6,  7'h52, 8'h81},  // R6 low byte 0x81
    {1'b1, 4'd3,  7'h32, 8'h02},  // R3 shift left of 0x81
    {1'b1, 4'd3,  7'h12, 8'h80},  // R3 plain masked view
    {1'b1, 4'd4,  7'h3A, 8'hFF},  // R4
    {1'b0, 4'd12, 7'h62, 8'h55},  // R12 ignored write
    {1'b0, 4'd12, 7'h7A, 8'h55},  // R12 ignored write
    {1'b0, 4'd12, 7'h2A, 8'h55},  // R12 write to a read view
    {1'b1, 4'd12, 7'h0A, 8'h7F},  // R12 pointer untouched
    {1'b1, 4'd12, 7'h4A, 8'h00},  // R12 write-only reads zero
    {1'b1, 4'd12, 7'h0A, 8'h7E},  // R12 that read moved nothing
    {1'b1, 4'd9,  7'h04, 8'h00},  // R9 all tone flags clear
    {1'b1, 4'd10, 7'h00, 8'h00},  // R10 sequence
    {1'b1, 4'd10, 7'h01, 8'h01},
    {1'b1, 4'd10, 7'h02, 8'h03},
    {1'b1, 4'd10, 7'h03, 8'h07},
    {1'b0, 4'd11, 7'h70, 8'h00},  // R11 clear by write
    {1'b1, 4'd11, 7'h00, 8'h00},
    {1'b1, 4'd10, 7'h00, 8'h01},
    {1'b1, 4'd11, 7'h75, 8'h00},  // R11 clear by read
    {1'b1, 4'd11, 7'h00, 8'h00},
    {1'b0, 4'd5,  7'h45, 8'h33},  // flag 5
    {1'b1, 4'd9,  7'h04, 8'h06},  // R9 index 100
    {1'b0, 4'd5,  7'h47, 8'h33},  // flag 7
    {1'b1, 4'd9,  7'h05, 8'h0A},  // R9 index 101
    {1'b0, 4'd5,  7'h46, 8'h33},  // flag 6
    {1'b1, 4'd9,  7'h06, 8'h0F},  // R9 index 111
    {1'b0, 4'd5,  7'h55, 8'h00},  // R5 low byte equals end: clear 5
    {1'b1, 4'd9,  7'h07, 8'h09}   // R9 index 011
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [6:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #2;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_tick(input int hold);
    @(negedge clk);
    osc_tick = 1'b1;
    repeat (hold) @(negedge clk);
    osc_tick = 1'b0;
  endtask

  function automatic logic [7:0] lfsr_next(input logic [7:0] v);
    return {v[6:0], ~(v[7] ^ v[5] ^ v[4] ^ v[3])};
  endfunction

  initial begin
    #(8 * 150000);
    n_err++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    do_rd(7'h38, 8'h00, "R1 flag0 after reset");
    do_rd(7'h3F, 8'h00, "R1 flag7 after reset");
    do_rd(7'h04, 8'h00, "R1 audio after reset");
    do_rd(7'h00, 8'h00, "R1 random after reset");
    do_wr(7'h70, 8'h00);

    for (int i = 0; i < NV; i++) begin
      automatic logic [19:0] v = VEC[i];
      if (v[19]) do_rd(v[14:8], v[7:0], $sformatf("R%0d vector %0d", v[18:15], i));
      else       do_wr(v[14:8], v[7:0]);
    end

    // R7 / R8 tone on fetcher 6, tick-clocked
    do_wr(7'h4E, 8'h01);
    do_wr(7'h46, 8'h03);
    do_wr(7'h5E, 8'h30);
    do_wr(7'h56, 8'h03);
    do_rd(7'h0E, 8'h03, "R8 read does not move tick-clocked");
    do_rd(7'h0E, 8'h03, "R8 second read same byte");
    pulse_tick(1); do_rd(7'h3E, 8'hFF, "R7 lo 02 flag set");
    pulse_tick(1); do_rd(7'h3E, 8'h00, "R7 lo 01 end clears");
    pulse_tick(1); do_rd(7'h3E, 8'h00, "R7 lo 00 flag clear");
    pulse_tick(1); do_rd(7'h3E, 8'hFF, "R7 reload sets flag");
    do_rd(7'h0E, 8'h03, "R7 reload to start");
    pulse_tick(3); do_rd(7'h0E, 8'h02, "R8 held tick counts once");
    pulse_tick(1); do_rd(7'h0E, 8'h01, "R8 next tick");
    do_wr(7'h5E, 8'h35);
    pulse_tick(1); pulse_tick(1);
    do_rd(7'h0E, 8'hA3, "R7 upper bits held through reload");

    // R8 tick-clocked without tone on fetcher 7
    do_wr(7'h5F, 8'h21);
    do_wr(7'h57, 8'h00);
    pulse_tick(1);
    do_rd(7'h0F, 8'hFF, "R8 full pointer decrement by tick");
    do_rd(7'h0F, 8'hFF, "R8 read leaves pointer");

    // R6 fetcher 4: bit 4 of high write ignored
    do_wr(7'h5C, 8'h13);
    do_wr(7'h54, 8'h10);
    do_rd(7'h0C, 8'h70, "R6 fetcher4 pointer 0x310");
    pulse_tick(1);
    do_rd(7'h0C, 8'h6F, "R6 bit4 at 0x5C no effect");

    // R10 full period from zero
    do_wr(7'h70, 8'h00);
    begin
      automatic logic [7:0] m = 8'h00;
      for (int i = 0; i < 255; i++) begin
        do_rd(7'h00, m, $sformatf("R10 read %0d", i));
        m = lfsr_next(m);
      end
      do_rd(7'h00, 8'h00, "R10 period 255");
    end

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    do_rd(7'h3E, 8'h00, "R1 flag6 after reset");
    do_rd(7'h0E, 8'h00, "R1 pointer6 after reset");
    do_rd(7'h00, 8'h00, "R1 random after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule